// File: doc/BRIEF.md
# Programmable Product-Term I/O Macrocell

This block is one input/output cell of a programmable logic array. It receives a set of regional array signals, which are local to its group of cells, and a set of universal signals. Its product terms are formed from both. A static configuration vector holds every product-term mask and every steering bit. From these the cell builds three OR-of-AND sum terms of unequal size. It can merge them into one combinatorial sum of 4, 5, 9 or 13 product terms. Two simple D registers capture the first and the third sum.

The pin side has three parts. The driven value comes from either the combinatorial sum or the first register. A single product term decides whether the pin is driven. The value returned to the array passes through an optional input latch that is clocked by the group's latch clock. A second steering bit picks what goes back to the array: the first register, or the combinatorial sum. This allows the register to drive the pin while the logic expansion term goes back into the array. It also allows both registers to stay buried while a combinatorial signal leaves through the pin.

Top module: `pt_io_cell`

## Requirements
- R1: Each product term has two mask bits per input, and input i uses bits [2i+1:2i]. The codes are: 00 ignores the input, 01 takes it true, 10 takes it complemented, and 11 forces the term to 0. In a sum, a term whose codes are all 00 contributes 0.
- R2: The universal inputs are {uni_in, reg_in}, with reg_in in the low bits. Universal masks sit at cfg[5+k*UW +: UW], where UW=2*(NR+NU): k=0 feeds sum A, k=1..2 feed sum B, k=3 feeds sum C, and k=4 is the enable term. Regional masks cover reg_in only and sit at cfg[5+5*UW+r*RW +: RW], where RW=2*NR: r=0..2 feed A, r=3..5 feed B, r=6..8 feed C.
- R3: cfg[1:0] selects the combinatorial sum: 00 gives B (5 terms), 01 gives A (4), 10 gives A|B (9), and 11 gives A|B|C (13).
- R4: On each rising clk edge, the first register loads sum A and the second loads sum C. q2_o always shows the second register. An active-low rst_n clears both registers at once.
- R5: cfg[2]=0 drives the combinatorial sum onto pin_o, and cfg[2]=1 drives the first register.
- R6: cfg[3]=0 sends the first register to fb_o, and cfg[3]=1 sends the combinatorial sum.
- R7: pin_oe is the AND of the enable term's selected inputs. With every code at 00, that term is 1.
- R8: With cfg[4]=0, pin_arr equals pin_i at all times, whatever lclk does.
- R9: With cfg[4]=1, pin_arr follows pin_i while lclk is low. It takes pin_i at the rising edge of lclk and holds that value while lclk stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Asynchronous active-low clear |
| cfg | input | 5+10*(NR+NU)+18*NR | Static masks and steering bits |
| reg_in | input | NR | Regional array inputs |
| uni_in | input | NU | Universal-only array inputs |
| pin_i | input | 1 | Value read from the pad |
| lclk | input | 1 | Input latch clock |
| pin_o | output | 1 | Value driven to the pad |
| pin_oe | output | 1 | Pad drive enable |
| fb_o | output | 1 | Selected feedback into the array |
| q2_o | output | 1 | Second register output |
| pin_arr | output | 1 | Pad value returned to the array |

## Verification
The assertions take cfg to be static for as long as the input latch is enabled and lclk is high. They also take lclk to change only away from rising clk edges. The bench holds to both rules. It changes every input, cfg included, only on falling clk edges. It keeps lclk low throughout the random configurations and raises lclk only in a dedicated latch sequence, during which the configuration stays fixed.

// File: rtl/pt_io_cell.sv
module pt_io_cell #(
  parameter int NR = 8,
  parameter int NU = 8,
  localparam int CFG_W = 5 + 10 * (NR + NU) + 18 * NR
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CFG_W-1:0] cfg,
  input  logic [NR-1:0]    reg_in,
  input  logic [NU-1:0]    uni_in,
  input  logic             pin_i,
  input  logic             lclk,
  output logic             pin_o,
  output logic             pin_oe,
  output logic             fb_o,
  output logic             q2_o,
  output logic             pin_arr
);
  localparam int NA    = NR + NU;
  localparam int UW    = 2 * NA;
  localparam int RW    = 2 * NR;
  localparam int UBASE = 5;
  localparam int RBASE = UBASE + 5 * UW;

  logic [NA-1:0] ua;
  logic [4:0]    ut;
  logic [3:0]    uany;
  logic [8:0]    rt, rany;
  logic          sa, sb, sc, comb, q1, q2, held;

  assign ua = {uni_in, reg_in};

  for (genvar k = 0; k < 5; k++) begin : g_uterm
    logic [NA-1:0] ok;
    for (genvar i = 0; i < NA; i++) begin : g_in
      logic [1:0] m;
      assign m     = cfg[UBASE + k*UW + 2*i +: 2];
      assign ok[i] = (m == 2'b00) | ((m == 2'b01) & ua[i]) | ((m == 2'b10) & ~ua[i]);
    end
    assign ut[k] = &ok;
    if (k < 4) begin : g_any
      logic [NA-1:0] used;
      for (genvar i = 0; i < NA; i++) begin : g_u
        assign used[i] = |cfg[UBASE + k*UW + 2*i +: 2];
      end
      assign uany[k] = |used;
    end
  end

  for (genvar r = 0; r < 9; r++) begin : g_rterm
    logic [NR-1:0] ok, used;
    for (genvar i = 0; i < NR; i++) begin : g_in
      logic [1:0] m;
      assign m       = cfg[RBASE + r*RW + 2*i +: 2];
      assign ok[i]   = (m == 2'b00) | ((m == 2'b01) & reg_in[i]) | ((m == 2'b10) & ~reg_in[i]);
      assign used[i] = |m;
    end
    assign rt[r]   = &ok;
    assign rany[r] = |used;
  end

  logic [3:0] up;
  logic [8:0] rp;
  assign up = ut[3:0] & uany;
  assign rp = rt & rany;

  assign sa = up[0] | (|rp[2:0]);
  assign sb = (|up[2:1]) | (|rp[5:3]);
  assign sc = up[3] | (|rp[8:6]);

  always_comb begin
    case (cfg[1:0])
      2'b00:   comb = sb;
      2'b01:   comb = sa;
      2'b10:   comb = sa | sb;
      default: comb = sa | sb | sc;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q1 <= 1'b0;
      q2 <= 1'b0;
    end else begin
      q1 <= sa;
      q2 <= sc;
    end
  end

  always_ff @(posedge lclk or negedge rst_n) begin
    if (!rst_n) held <= 1'b0;
    else        held <= pin_i;
  end

  assign pin_o   = cfg[2] ? q1 : comb;
  assign fb_o    = cfg[3] ? comb : q1;
  assign q2_o    = q2;
  assign pin_oe  = ut[4];
  assign pin_arr = (cfg[4] & lclk) ? held : pin_i;
endmodule

module pt_io_cell_chk (
  input logic clk,
  input logic rst_n,
  input logic out_sel,
  input logic fb_sel,
  input logic lat_en,
  input logic pin_o,
  input logic fb_o,
  input logic q2_o,
  input logic pin_i,
  input logic lclk,
  input logic pin_arr,
  input logic s_c
);
  // R4
  q_clear_chk: assert property (@(posedge clk) !rst_n |-> (q2_o == 1'b0));

  // R4
  q2_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (q2_o == $past(s_c)));

  // R5
  reg_both_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_sel && !fb_sel) |-> (pin_o == fb_o));

  // R8
  lat_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lat_en |-> (pin_arr == pin_i));

  // R9
  lat_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lat_en && !lclk) |-> (pin_arr == pin_i));

  // R9
  lat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lat_en && $past(lat_en) && lclk && $past(lclk)) |-> $stable(pin_arr));
endmodule

bind pt_io_cell pt_io_cell_chk u_chk (
  .clk(clk), .rst_n(rst_n), .out_sel(cfg[2]), .fb_sel(cfg[3]), .lat_en(cfg[4]),
  .pin_o(pin_o), .fb_o(fb_o), .q2_o(q2_o), .pin_i(pin_i), .lclk(lclk),
  .pin_arr(pin_arr), .s_c(sc)
);

// File: tb/tb_pt_io_cell.sv
module tb_pt_io_cell;
  localparam int NR = 8, NU = 8, NA = NR + NU;
  localparam int UW = 2 * NA, RW = 2 * NR;
  localparam int CW = 5 + 5 * UW + 9 * RW;
  localparam int RBASE = 5 + 5 * UW;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [CW-1:0] cfg = '0;
  logic [NR-1:0] reg_in = '0;
  logic [NU-1:0] uni_in = '0;
  logic pin_i = 1'b0, lclk = 1'b0;
  logic pin_o, pin_oe, fb_o, q2_o, pin_arr;

  always #4 clk = ~clk;

  pt_io_cell #(.NR(NR), .NU(NU)) dut (
    .clk(clk), .rst_n(rst_n), .cfg(cfg), .reg_in(reg_in), .uni_in(uni_in),
    .pin_i(pin_i), .lclk(lclk), .pin_o(pin_o), .pin_oe(pin_oe), .fb_o(fb_o),
    .q2_o(q2_o), .pin_arr(pin_arr)
  );

  typedef struct {
    logic po, oe, fb, q2, pa;
    string tag;
  } exp_t;

  exp_t sb_q[$];
  int n_cmp = 0, n_bad = 0;

  task automatic chk(input logic act, input logic exp, input string req, input string what);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  function automatic logic [1:0] pt(input logic [NA-1:0] x, input logic [2*NA-1:0] m);
    logic s, v;
    s = 1'b0;
    v = 1'b1;
    for (int i = 0; i < NA; i++) begin
      case (m[2*i +: 2])
        2'b01: begin s = 1'b1; v = v & x[i]; end
        2'b10: begin s = 1'b1; v = v & ~x[i]; end
        2'b11: begin s = 1'b1; v = 1'b0; end
        default: ;
      endcase
    end
    return {s, v};
  endfunction

  function automatic logic usum(input logic [CW-1:0] c, input logic [NA-1:0] x, input int k);
    logic [1:0] p;
    p = pt(x, c[5 + k*UW +: UW]);
    return p[1] & p[0];
  endfunction

  function automatic logic rsum(input logic [CW-1:0] c, input logic [NR-1:0] r, input int k);
    logic [1:0] p;
    p = pt({{NU{1'b0}}, r}, {{(2*NU){1'b0}}, c[RBASE + k*RW +: RW]});
    return p[1] & p[0];
  endfunction

  function automatic exp_t model(input logic [CW-1:0] c, input logic [NR-1:0] r,
                                 input logic [NU-1:0] u, input logic p, input string tag);
    exp_t e;
    logic [NA-1:0] x;
    logic a, b, cc, cmb;
    logic [1:0] o;
    x  = {u, r};
    a  = usum(c, x, 0) | rsum(c, r, 0) | rsum(c, r, 1) | rsum(c, r, 2);
    b  = usum(c, x, 1) | usum(c, x, 2) | rsum(c, r, 3) | rsum(c, r, 4) | rsum(c, r, 5);
    cc = usum(c, x, 3) | rsum(c, r, 6) | rsum(c, r, 7) | rsum(c, r, 8);
    case (c[1:0])
      2'b00: cmb = b;
      2'b01: cmb = a;
      2'b10: cmb = a | b;
      default: cmb = a | b | cc;
    endcase
    o     = pt(x, c[5 + 4*UW +: UW]);
    e.po  = c[2] ? a : cmb;
    e.fb  = c[3] ? cmb : a;
    e.q2  = cc;
    e.oe  = o[0];
    e.pa  = p;
    e.tag = tag;
    return e;
  endfunction

  task automatic drive(input logic [CW-1:0] c, input logic [NR-1:0] r,
                       input logic [NU-1:0] u, input logic p, input string tag);
    @(negedge clk);
    cfg = c; reg_in = r; uni_in = u; pin_i = p;
    sb_q.push_back(model(c, r, u, p, tag));
  endtask

  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (sb_q.size() > 0) begin
        exp_t e;
        e = sb_q.pop_front();
        chk(pin_o,   e.po, "R5", {e.tag, " pin_o"});
        chk(fb_o,    e.fb, "R6", {e.tag, " fb_o"});
        chk(q2_o,    e.q2, "R4", {e.tag, " q2_o"});
        chk(pin_oe,  e.oe, "R7", {e.tag, " pin_oe"});
        chk(pin_arr, e.pa, "R8", {e.tag, " pin_arr"});
      end
    end
  end

  function automatic logic [2*NA-1:0] rmask(input int n);
    logic [2*NA-1:0] m;
    m = '0;
    for (int i = 0; i < n; i++) begin
      int d;
      d = $urandom_range(0, 99);
      m[2*i +: 2] = (d < 85) ? 2'b00 : (d < 93) ? 2'b01 : (d < 99) ? 2'b10 : 2'b11;
    end
    return m;
  endfunction

  function automatic logic [CW-1:0] rcfg();
    logic [CW-1:0] c;
    logic [2*NA-1:0] m;
    c = '0;
    c[4:0] = 5'($urandom_range(0, 31));
    for (int k = 0; k < 5; k++) c[5 + k*UW +: UW] = rmask(NA);
    for (int k = 0; k < 9; k++) begin
      m = rmask(NR);
      c[RBASE + k*RW +: RW] = m[RW-1:0];
    end
    return c;
  endfunction

  initial begin
    #(8 * 200000);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [CW-1:0] c;
    cfg = '0;
    cfg[2] = 1'b1;
    repeat (3) @(posedge clk);
    #2;
    // R4: the registers stay cleared while reset is held
    chk(q2_o, 1'b0, "R4", "reset q2_o");
    chk(pin_o, 1'b0, "R4", "reset pin_o from first register");
    chk(fb_o, 1'b0, "R4", "reset fb_o");
    @(negedge clk);
    rst_n = 1'b1;

    // R3: one B term selecting reg_in[0] true
    c = '0;
    c[RBASE + 3*RW +: 2] = 2'b01;
    for (int s = 0; s < 4; s++) begin
      c[1:0] = 2'(s);
      drive(c, 8'h01, '0, 1'b0, "R3 merge");
    end
    // R2: C universal term takes uni_in[2] complemented
    c[5 + 3*UW + 2*(NR+2) +: 2] = 2'b10;
    c[3] = 1'b1;
    for (int s = 0; s < 4; s++) begin
      c[1:0] = 2'(s);
      drive(c, 8'h00, 8'h00, 1'b1, "R2 regional-blind C");
      drive(c, 8'h01, 8'h04, 1'b0, "R2 universal C");
    end
    // R1: code 11 kills the B term; an all-unused sum stays 0
    c = '0;
    c[RBASE + 3*RW +: 4] = 4'b1101;
    drive(c, 8'h03, '0, 1'b0, "R1 forced-zero");
    c = '0;
    c[1:0] = 2'b11;
    drive(c, 8'hFF, 8'hFF, 1'b1, "R1 all-unused");
    // R7: enable term on uni_in[0]
    c[5 + 4*UW + 2*NR +: 2] = 2'b01;
    drive(c, '0, 8'h01, 1'b0, "R7 enable high");
    drive(c, '0, 8'h00, 1'b0, "R7 enable low");

    for (int t = 0; t < 400; t++)
      drive(rcfg(), 8'($urandom), 8'($urandom), 1'($urandom), "RND");

    repeat (3) @(posedge clk);

    // R9: latch enabled, transparent then hold
    @(negedge clk);
    cfg = '0; cfg[4] = 1'b1; pin_i = 1'b1; lclk = 1'b0;
    #2 chk(pin_arr, 1'b1, "R9", "transparent while lclk low");
    @(negedge clk);
    lclk = 1'b1;
    #2 chk(pin_arr, 1'b1, "R9", "captured at lclk rise");
    @(negedge clk);
    pin_i = 1'b0;
    #2 chk(pin_arr, 1'b1, "R9", "held while lclk high");
    @(negedge clk);
    pin_i = 1'b1;
    @(negedge clk);
    pin_i = 1'b0;
    #2 chk(pin_arr, 1'b1, "R9", "still held");
    @(negedge clk);
    lclk = 1'b0;
    #2 chk(pin_arr, 1'b0, "R9", "transparent again");
    // R8: latch disabled ignores lclk
    @(negedge clk);
    cfg[4] = 1'b0; pin_i = 1'b1;
    @(negedge clk);
    lclk = 1'b1;
    @(negedge clk);
    pin_i = 1'b0;
    #2 chk(pin_arr, 1'b0, "R8", "bypass with lclk high");
    @(negedge clk);
    lclk = 1'b0;
    repeat (2) @(posedge clk);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule